// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog counter that runs on every system clock. Once started, it first raises an interrupt flag when the selected timeout elapses. If software does not restart the counter within a fixed grace window after that, the block issues a one-cycle system reset request. It also records that the watchdog caused the reset in a flag that the reset itself leaves set.

A 2-bit select picks one of four interrupt timeouts, each a power of two. The grace window between the interrupt point and the reset point is the same for all four. Two control actions are protected: restarting the counter and writing the reset-enable bit. Each takes effect only in a cycle in which the protected-write permit input is high. The permit is generated outside this block. The interrupt enable does not stop the flag from being set. It only gates the interrupt line.

Top module: `wdt_dual_top`

## Requirements
- R1: While rst_n is low and in the first cycle after it is released, irq_flag, wdt_irq, cause_flag, sys_rst_req and rst_en_q are all 0.
- R2: With period_sel = s, irq_flag rises exactly 2^(BASE_EXP + STEP_EXP*s) clock edges after the edge that restarted the counter. The defaults give 2^17, 2^20, 2^23 and 2^26 for s = 0..3.
- R3: When rst_en_q is 1, sys_rst_req goes high for exactly one cycle. This happens RST_DELAY (default 512) clock edges after the edge at which irq_flag rose, unless the counter was restarted in between.
- R4: A restart_req pulse clears the counter only if ta_ok is high in the same cycle. Without ta_ok, the pulse has no effect on when the timeout occurs.
- R5: rst_en_q takes the value of rst_en_din only at an edge where rst_en_wr and ta_ok are both high. Otherwise it holds its value, except when a watchdog reset clears it.
- R6: When rst_en_q is 0, no reset request is issued at the reset point. Instead, the counter returns to zero there, so the interrupt timeout repeats one full period plus RST_DELAY later.
- R7: irq_flag stays set until an irq_flag_clr pulse clears it. If a clear and a new timeout occur at the same edge, the flag ends up set.
- R8: wdt_irq is high only while both irq_flag and irq_en are high.
- R9: At the edge where a watchdog reset is issued, cause_flag is set, and irq_flag and rst_en_q are cleared. cause_flag then stays set until cause_clr or rst_n clears it.
- R10: A change of period_sel restarts the counter from zero. The new timeout is measured from the edge that samples the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_sel | input | 2 | Interrupt timeout select |
| restart_req | input | 1 | Restart strobe (needs ta_ok) |
| ta_ok | input | 1 | Protected-write permit for this cycle |
| rst_en_wr | input | 1 | Write strobe for the reset-enable bit (needs ta_ok) |
| rst_en_din | input | 1 | Value written to the reset-enable bit |
| irq_en | input | 1 | Interrupt enable |
| irq_flag_clr | input | 1 | Clears the interrupt flag |
| cause_clr | input | 1 | Clears the reset-cause flag |
| irq_flag | output | 1 | Watchdog interrupt flag |
| wdt_irq | output | 1 | Interrupt request, flag gated by irq_en |
| rst_en_q | output | 1 | Current reset-enable state |
| cause_flag | output | 1 | Watchdog-caused-reset flag |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
On every cycle, the checker enforces these properties:
- the reset request is a single-cycle pulse that needs reset enable;
- a reset sets the cause flag and clears the interrupt flag and reset enable;
- reset enable changes only under permit;
- the interrupt line follows its enable;
- both flags are sticky.

The exact timeout lengths for each select value, the 512-clock offset of the reset, and the wrap when reset is disabled can only be shown by the bench's timed scenarios. The same holds for rejecting an unpermitted restart and for restarting on a select change. For those scenarios, the bench builds a small-period instance and schedules the expected flag edges by cycle number.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef struct packed {
    logic irq_hit;
    logic rst_hit;
  } wdt_hit_t;

  localparam int NUM_PERIODS = 4;

  function automatic int period_exp(input int base_exp, input int step_exp, input int idx);
    return base_exp + step_exp * idx;
  endfunction

endpackage

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
  import wdt_pkg::*;
#(
  parameter int BASE_EXP  = 17,
  parameter int STEP_EXP  = 3,
  parameter int RST_DELAY = 512,
  parameter int CW        = 27
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    period_sel,
  output logic [CW-1:0] irq_last,
  output logic [CW-1:0] rst_last,
  output logic          sel_chg
);

  logic [CW-1:0] irq_tab [NUM_PERIODS];
  logic [CW-1:0] rst_tab [NUM_PERIODS];

  for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_lim
    localparam int            EXP_G = period_exp(BASE_EXP, STEP_EXP, g);
    localparam logic [CW-1:0] LIM_I = CW'((64'd1 << EXP_G) - 64'd1);
    localparam logic [CW-1:0] LIM_R = CW'((64'd1 << EXP_G) + 64'(RST_DELAY) - 64'd1);
    assign irq_tab[g] = LIM_I;
    assign rst_tab[g] = LIM_R;
  end

  logic [1:0] sel_q, sel_d;

  always_comb begin
    sel_d    = period_sel;
    sel_chg  = (period_sel != sel_q);
    irq_last = irq_tab[period_sel];
    rst_last = rst_tab[period_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 2'd0;
    else        sel_q <= sel_d;
  end

endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int CW = 27
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] irq_last,
  input  logic [CW-1:0] rst_last,
  output wdt_hit_t      hit
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_irq, at_rst;

  always_comb begin
    at_irq      = (cnt_q == irq_last);
    at_rst      = (cnt_q == rst_last);
    hit.irq_hit = at_irq && !clr;
    hit.rst_hit = at_rst && !clr;
    if (clr || at_rst) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wdt_hit_t hit,
  input  logic     restart_req,
  input  logic     ta_ok,
  input  logic     rst_en_wr,
  input  logic     rst_en_din,
  input  logic     irq_en,
  input  logic     irq_flag_clr,
  input  logic     cause_clr,
  output logic     restart_ok,
  output logic     irq_flag,
  output logic     wdt_irq,
  output logic     rst_en_q,
  output logic     cause_flag,
  output logic     sys_rst_req
);

  logic fire;
  logic irq_d, en_d, cause_d, req_d;
  logic en_we;

  always_comb begin
    restart_ok = restart_req && ta_ok;
    fire       = hit.rst_hit && rst_en_q;
    en_we      = rst_en_wr && ta_ok;

    if (fire)              irq_d = 1'b0;
    else if (hit.irq_hit)  irq_d = 1'b1;
    else if (irq_flag_clr) irq_d = 1'b0;
    else                   irq_d = irq_flag;

    if (fire)       en_d = 1'b0;
    else if (en_we) en_d = rst_en_din;
    else            en_d = rst_en_q;

    if (fire)           cause_d = 1'b1;
    else if (cause_clr) cause_d = 1'b0;
    else                cause_d = cause_flag;

    req_d   = fire;
    wdt_irq = irq_flag && irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag    <= 1'b0;
      rst_en_q    <= 1'b0;
      cause_flag  <= 1'b0;
      sys_rst_req <= 1'b0;
    end else begin
      irq_flag    <= irq_d;
      rst_en_q    <= en_d;
      cause_flag  <= cause_d;
      sys_rst_req <= req_d;
    end
  end

endmodule

// File: rtl/wdt_dual_top.sv
module wdt_dual_top
  import wdt_pkg::*;
#(
  parameter int BASE_EXP  = 17,
  parameter int STEP_EXP  = 3,
  parameter int RST_DELAY = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] period_sel,
  input  logic       restart_req,
  input  logic       ta_ok,
  input  logic       rst_en_wr,
  input  logic       rst_en_din,
  input  logic       irq_en,
  input  logic       irq_flag_clr,
  input  logic       cause_clr,
  output logic       irq_flag,
  output logic       wdt_irq,
  output logic       rst_en_q,
  output logic       cause_flag,
  output logic       sys_rst_req
);

  localparam int MAX_EXP = period_exp(BASE_EXP, STEP_EXP, NUM_PERIODS - 1);
  localparam int CW      = MAX_EXP + 1;

  logic [CW-1:0] irq_last, rst_last;
  logic          sel_chg, restart_ok, cnt_clr;
  wdt_hit_t      hit;

  assign cnt_clr = restart_ok || sel_chg;

  wdt_period_sel #(
    .BASE_EXP (BASE_EXP),
    .STEP_EXP (STEP_EXP),
    .RST_DELAY(RST_DELAY),
    .CW       (CW)
  ) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .period_sel(period_sel),
    .irq_last  (irq_last),
    .rst_last  (rst_last),
    .sel_chg   (sel_chg)
  );

  wdt_count #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cnt_clr),
    .irq_last(irq_last),
    .rst_last(rst_last),
    .hit     (hit)
  );

  wdt_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit         (hit),
    .restart_req (restart_req),
    .ta_ok       (ta_ok),
    .rst_en_wr   (rst_en_wr),
    .rst_en_din  (rst_en_din),
    .irq_en      (irq_en),
    .irq_flag_clr(irq_flag_clr),
    .cause_clr   (cause_clr),
    .restart_ok  (restart_ok),
    .irq_flag    (irq_flag),
    .wdt_irq     (wdt_irq),
    .rst_en_q    (rst_en_q),
    .cause_flag  (cause_flag),
    .sys_rst_req (sys_rst_req)
  );

endmodule

// File: rtl/wdt_dual_chk.sv
module wdt_dual_chk (
  input logic clk,
  input logic rst_n,
  input logic ta_ok,
  input logic rst_en_wr,
  input logic irq_en,
  input logic irq_flag_clr,
  input logic cause_clr,
  input logic irq_flag,
  input logic wdt_irq,
  input logic rst_en_q,
  input logic cause_flag,
  input logic sys_rst_req
);

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req); // R3

  AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(rst_en_q)); // R6

  AST_RST_SIDE_EFFECTS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> (cause_flag && !irq_flag && !rst_en_q)); // R9

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cause_flag) && !$past(cause_clr)) |-> cause_flag); // R9

  AST_EN_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ta_ok && rst_en_wr) && !sys_rst_req) |-> $stable(rst_en_q)); // R5

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_irq |-> irq_en); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_flag) && !$past(irq_flag_clr) && !sys_rst_req) |-> irq_flag); // R7

endmodule

bind wdt_dual_top wdt_dual_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ta_ok       (ta_ok),
  .rst_en_wr   (rst_en_wr),
  .irq_en      (irq_en),
  .irq_flag_clr(irq_flag_clr),
  .cause_clr   (cause_clr),
  .irq_flag    (irq_flag),
  .wdt_irq     (wdt_irq),
  .rst_en_q    (rst_en_q),
  .cause_flag  (cause_flag),
  .sys_rst_req (sys_rst_req)
);

// File: tb/wdt_dual_top_test.sv
`timescale 1ns/1ps
module wdt_dual_top_test;

  localparam int BE  = 6;
  localparam int SE  = 2;
  localparam int DLY = 512;

  function automatic int tper(input int s);
    return 1 << (BE + SE * s);
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] period_sel = 2'd0;
  logic restart_req = 1'b0, ta_ok = 1'b0, rst_en_wr = 1'b0, rst_en_din = 1'b0;
  logic irq_en = 1'b0, irq_flag_clr = 1'b0, cause_clr = 1'b0;
  logic irq_flag, wdt_irq, rst_en_q, cause_flag, sys_rst_req;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;

  typedef enum {SIG_IRQ, SIG_WIRQ, SIG_RST, SIG_CAUSE} sig_e;
  typedef struct {
    int    at;
    sig_e  s;
    logic  v;
    string tag;
  } exp_t;
  exp_t sbq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_dual_top #(.BASE_EXP(BE), .STEP_EXP(SE), .RST_DELAY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .period_sel(period_sel), .restart_req(restart_req),
    .ta_ok(ta_ok), .rst_en_wr(rst_en_wr), .rst_en_din(rst_en_din), .irq_en(irq_en),
    .irq_flag_clr(irq_flag_clr), .cause_clr(cause_clr), .irq_flag(irq_flag),
    .wdt_irq(wdt_irq), .rst_en_q(rst_en_q), .cause_flag(cause_flag),
    .sys_rst_req(sys_rst_req)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic pick(input sig_e s);
    case (s)
      SIG_IRQ:  return irq_flag;
      SIG_WIRQ: return wdt_irq;
      SIG_RST:  return sys_rst_req;
      default:  return cause_flag;
    endcase
  endfunction

  task automatic expect_at(input int at, input sig_e s, input logic v, input string tag);
    exp_t e;
    int   idx;
    e.at = at; e.s = s; e.v = v; e.tag = tag;
    idx = sbq.size();
    for (int i = 0; i < sbq.size(); i++) begin
      if (sbq[i].at > at) begin idx = i; break; end
    end
    sbq.insert(idx, e);
  endtask

  // monitor: compares scheduled expectations at the falling edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      while (sbq.size() > 0 && sbq[0].at <= cyc) begin
        e = sbq.pop_front();
        if (e.at < cyc) begin
          n_chk++; n_err++;
          $display("FAIL %s: actual missed expected check at cycle %0d", e.tag, e.at);
        end else begin
          check(e.tag, pick(e.s), e.v);
        end
      end
    end
  end

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_restart(input logic permit, output int p);
    @(negedge clk); restart_req = 1'b1; ta_ok = permit;
    @(negedge clk); p = cyc; restart_req = 1'b0; ta_ok = 1'b0;
  endtask

  task automatic write_en(input logic permit, input logic v);
    @(negedge clk); rst_en_wr = 1'b1; rst_en_din = v; ta_ok = permit;
    @(negedge clk); rst_en_wr = 1'b0; ta_ok = 1'b0;
  endtask

  task automatic set_sel(input int s, output int p);
    @(negedge clk); period_sel = 2'(s);
    @(negedge clk); p = cyc;
  endtask

  task automatic clr_irq();
    @(negedge clk); irq_flag_clr = 1'b1;
    @(negedge clk); irq_flag_clr = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL all: watchdog expired, actual still running expected completion");
    summary();
    $finish;
  end

  initial begin
    int p, q, t;
    repeat (4) @(negedge clk);
    check("R1 irq_flag", irq_flag, 1'b0);
    check("R1 cause_flag", cause_flag, 1'b0);
    check("R1 sys_rst_req", sys_rst_req, 1'b0);
    check("R1 rst_en_q", rst_en_q, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 wdt_irq after release", wdt_irq, 1'b0);
    irq_en = 1'b1;

    // R5: unpermitted write ignored, permitted write takes effect
    write_en(1'b0, 1'b1);
    check("R5 write without permit", rst_en_q, 1'b0);
    write_en(1'b1, 1'b1);
    check("R5 write with permit", rst_en_q, 1'b1);

    // R2/R3/R8/R9: full two-stage timeout on select 0
    t = tper(0);
    do_restart(1'b1, p);
    expect_at(p + t - 1, SIG_IRQ, 1'b0, "R2 before timeout");
    expect_at(p + t, SIG_IRQ, 1'b1, "R2 at timeout");
    expect_at(p + t, SIG_WIRQ, 1'b1, "R8 line follows flag");
    expect_at(p + t + DLY - 1, SIG_RST, 1'b0, "R3 before reset point");
    expect_at(p + t + DLY, SIG_RST, 1'b1, "R3 reset pulse");
    expect_at(p + t + DLY, SIG_CAUSE, 1'b1, "R9 cause set");
    expect_at(p + t + DLY, SIG_IRQ, 1'b0, "R9 flag cleared by reset");
    expect_at(p + t + DLY + 1, SIG_RST, 1'b0, "R3 pulse one cycle");
    drain();
    check("R9 reset enable cleared", rst_en_q, 1'b0);
    repeat (5) @(negedge clk);
    check("R9 cause held", cause_flag, 1'b1);
    @(negedge clk); cause_clr = 1'b1;
    @(negedge clk); cause_clr = 1'b0;
    check("R9 cause cleared", cause_flag, 1'b0);

    // R4/R7/R6: ignored restart, clear/set collision, wrap without reset
    do_restart(1'b1, p);
    expect_at(p + t - 1, SIG_IRQ, 1'b0, "R4 not early");
    expect_at(p + t, SIG_IRQ, 1'b1, "R4 unpermitted restart ignored / R7 set wins");
    expect_at(p + t + DLY, SIG_RST, 1'b0, "R6 no reset when disabled");
    expect_at(p + t + DLY, SIG_CAUSE, 1'b0, "R6 no cause when disabled");
    expect_at(p + 2 * t + DLY - 1, SIG_IRQ, 1'b0, "R6 before repeat");
    expect_at(p + 2 * t + DLY, SIG_IRQ, 1'b1, "R6 repeat timeout");
    repeat (30) @(negedge clk);
    do_restart(1'b0, q);
    while (cyc != p + t - 1) @(negedge clk);
    irq_flag_clr = 1'b1;
    @(negedge clk); irq_flag_clr = 1'b0;
    repeat (10) @(negedge clk);
    check("R7 flag sticky", irq_flag, 1'b1);
    clr_irq();
    check("R7 flag cleared", irq_flag, 1'b0);
    drain();

    // R8: enable gates the line only
    irq_en = 1'b0;
    @(negedge clk);
    check("R8 line off with enable low", wdt_irq, 1'b0);
    check("R8 flag unaffected", irq_flag, 1'b1);
    irq_en = 1'b1;
    @(negedge clk);
    check("R8 line on with enable high", wdt_irq, 1'b1);
    clr_irq();

    // R2: remaining periods
    for (int s = 1; s < 4; s++) begin
      set_sel(s, q);
      do_restart(1'b1, p);
      expect_at(p + tper(s) - 1, SIG_IRQ, 1'b0, "R2 before timeout");
      expect_at(p + tper(s), SIG_IRQ, 1'b1, "R2 at timeout");
      drain();
      clr_irq();
    end

    // R10: select change restarts the count
    do_restart(1'b1, p);
    repeat (100) @(negedge clk);
    set_sel(0, q);
    expect_at(q + tper(0) - 1, SIG_IRQ, 1'b0, "R10 before new timeout");
    expect_at(q + tper(0), SIG_IRQ, 1'b1, "R10 new timeout from change");
    drain();

    summary();
    $finish;
  end

endmodule